// File: doc/BRIEF.md
# Word-Addressed Stack Processor Core

This block is a small multicycle processor for a 22-opcode instruction set. Every memory word is 16 bits wide, and every memory address names one word. Data values are 15 bits wide, and all arithmetic wraps modulo 32768. The core has eight general registers and an internal last-in first-out stack. The stack is a RAM whose depth is a parameter.

Instructions are one to four words long. The first word is the opcode and the rest are operand words. Each operand word is decoded as follows:
- a value below 32768 is a literal;
- a value from 32768 to 32775 names register 0 to 7.

The core reads memory one word at a time through a synchronous port that has one cycle of read latency. Because every fetch goes back to memory, a store into the code area changes what the core later executes.

Characters leave the core through a byte-wide valid/ready output handshake. Characters enter through a byte-wide valid/ready input handshake. When the core stops, it raises `halted`. If it stopped because something went wrong, it also raises `fault`.

Top module: `wstk_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `halted`, `fault`, `out_valid` and `in_ready` are 0, and `mem_addr` is 0. The first fetch is from word 0.
- R2: An operand word below 32768 is a literal. An operand word 32768+k (k = 0..7) reads or writes register k. Set (opcode 1, dest, src) copies its source into the destination register.
- R3: An instruction is one opcode word plus its operand words, and the next instruction follows it directly. Jmp (opcode 6, target) continues at the target word address.
- R4: Add (9) and mult (10), both with operands dest, x, y, keep the low 15 bits of the result. For example, adding 0x7FFE subtracts 2.
- R5: The following opcodes all take dest, x, y except not, which takes dest, x:
  - and (12) and or (13) are bitwise;
  - not (14) inverts the 15 data bits, so not 0xC gives 0x7FF3;
  - mod (11) gives the remainder of x divided by y.
- R6: Eq (4) and gt (5), with operands dest, x, y, write 1 when the condition holds and 0 otherwise. Gt is an unsigned strict compare.
- R7: Jt (7, cond, target) branches when cond is nonzero. Jf (8, cond, target) branches when cond is zero. When the branch is not taken, the core falls through to the next instruction.
- R8: The stack operations behave as follows:
  - push (2, src) and pop (3, dest) are last-in first-out;
  - call (17, target) pushes the address of the word after the call and then jumps to the target;
  - ret (18) pops an address and continues there.
- R9: Rmem (15, dest, addr) loads a word. Wmem (16, addr, value) stores a word. The address may be a literal or a register. A store into an instruction word changes what later fetches return.
- R10: Out (19, src) presents the low 8 bits of src on `out_data` with `out_valid` high. The core holds `out_valid` and `out_data` steady until a cycle in which `out_ready` is high.
- R11: In (20, dest) raises `in_ready` and waits for `in_valid`. It then writes `in_data`, zero-extended, into the destination register, accepting exactly one byte.
- R12: Halt (0) stops the core for good with `halted` = 1 and `fault` = 0. After it stops, the core performs no output, no input and no memory write.
- R13: The core stops with both `halted` and `fault` set in any of these cases:
  - an opcode word above 21;
  - an operand word of 32776 or more;
  - a literal in a destination position;
  - mod by zero;
  - pop or ret with an empty stack;
  - push or call with a full stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| mem_addr | output | 15 | Word address for a read or write |
| mem_wr_en | output | 1 | Write strobe; writes mem_wdata at mem_addr |
| mem_wdata | output | 16 | Word to store |
| mem_rdata | input | 16 | Word read from the previous cycle's mem_addr |
| out_valid | output | 1 | Output character pending |
| out_ready | input | 1 | Consumer accepts the character this cycle |
| out_data | output | 8 | Output character |
| in_valid | input | 1 | Input character offered |
| in_data | input | 8 | Input character |
| in_ready | output | 1 | Core waits for an input character |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Core stopped because of an error |

## Verification
The bench targets the following corner cases, each with the symptom a faulty design would show:
- Wrapping arithmetic: a design that did not wrap arithmetic modulo 32768 would print the wrong low byte for the 300×200 product and for the 0x7FFE addition.
- Unsigned compare: a signed gt would report 0x7FFF > 1 as false.
- Not width: a not over all 16 bits would fail the 0x7FF3 compare.
- Fall-through: a branch that fell through on the wrong polarity would emit a marker byte or restart the program.
- Self-modifying code: one program overwrites an operand word and an opcode word just ahead of execution. A core that cached or prefetched instructions would print the stale byte or stop early.
- Output stall: the output consumer is throttled to one accept in three cycles, so a core that dropped or changed a pending byte shows up as a repeat, a miss or a changed value.
- Error stops: each fault cause and stack overflow runs in its own short program. A missed check would either keep running or stop without `fault`.

// File: rtl/wstk_pkg.sv
package wstk_pkg;

  typedef enum logic [4:0] {
    OP_HALT = 5'd0,  OP_SET  = 5'd1,  OP_PUSH = 5'd2,  OP_POP  = 5'd3,
    OP_EQ   = 5'd4,  OP_GT   = 5'd5,  OP_JMP  = 5'd6,  OP_JT   = 5'd7,
    OP_JF   = 5'd8,  OP_ADD  = 5'd9,  OP_MULT = 5'd10, OP_MOD  = 5'd11,
    OP_AND  = 5'd12, OP_OR   = 5'd13, OP_NOT  = 5'd14, OP_RMEM = 5'd15,
    OP_WMEM = 5'd16, OP_CALL = 5'd17, OP_RET  = 5'd18, OP_OUT  = 5'd19,
    OP_IN   = 5'd20, OP_NOOP = 5'd21
  } opcode_e;

  localparam int unsigned OP_LAST = 21;

  typedef enum logic [2:0] {
    ST_ISSUE, ST_CAPT, ST_EXEC, ST_RMEM, ST_OUT, ST_IN, ST_STOP
  } state_e;

  // Number of operand words that follow the opcode word.
  function automatic logic [1:0] opnd_count(input opcode_e op);
    case (op)
      OP_HALT, OP_RET, OP_NOOP:                       return 2'd0;
      OP_PUSH, OP_POP, OP_JMP, OP_CALL, OP_OUT, OP_IN: return 2'd1;
      OP_SET, OP_JT, OP_JF, OP_NOT, OP_RMEM, OP_WMEM:  return 2'd2;
      default:                                        return 2'd3;
    endcase
  endfunction

  // Opcodes whose first operand must name a register.
  function automatic logic writes_dest(input opcode_e op);
    case (op)
      OP_SET, OP_POP, OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
      OP_AND, OP_OR, OP_NOT, OP_RMEM, OP_IN: return 1'b1;
      default:                               return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wstk_alu.sv
module wstk_alu
  import wstk_pkg::*;
#(
  parameter int DATA_W = 15
) (
  input  opcode_e             op,
  input  logic [DATA_W-1:0]   x,
  input  logic [DATA_W-1:0]   y,
  output logic [DATA_W-1:0]   res,
  output logic                div_zero
);

  always_comb begin
    div_zero = (op == OP_MOD) && (y == '0);
    case (op)
      OP_EQ:   res = {{(DATA_W-1){1'b0}}, (x == y)};
      OP_GT:   res = {{(DATA_W-1){1'b0}}, (x > y)};
      OP_ADD:  res = x + y;   // same-width sum keeps the wrapped bits
      OP_MULT: res = x * y;   // same-width product keeps the low bits
      OP_MOD:  res = div_zero ? '0 : (x % y);
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      OP_NOT:  res = ~x;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/wstk_regfile.sv
module wstk_regfile #(
  parameter  int DATA_W = 15,
  parameter  int NREG   = 8,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra,
  input  logic [IDX_W-1:0]  rb,
  input  logic [IDX_W-1:0]  rc,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb,
  output logic [DATA_W-1:0] qc
);

  logic [NREG*DATA_W-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              en;
    assign en = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = q;
  end

  assign qa = flat[ra*DATA_W +: DATA_W];
  assign qb = flat[rb*DATA_W +: DATA_W];
  assign qc = flat[rc*DATA_W +: DATA_W];

endmodule

// File: rtl/wstk_stack.sv
module wstk_stack #(
  parameter  int DATA_W = 15,
  parameter  int DEPTH  = 64,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] top,
  output logic              empty,
  output logic              full
);

  logic [DATA_W-1:0] ram [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (push)     cnt_d = cnt_q + CNT_W'(1);
    else if (pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push) ram[PTR_W'(cnt_q)] <= wdata;
  end

  assign top   = ram[PTR_W'(cnt_q - CNT_W'(1))];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R8: the sequencer never pops an empty stack or pushes a full one
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_push_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !empty);

endmodule

// File: rtl/wstk_core.sv
module wstk_core
  import wstk_pkg::*;
#(
  parameter  int DATA_W      = 15,
  parameter  int NREG        = 8,
  parameter  int STACK_DEPTH = 64,
  parameter  int CHAR_W      = 8,
  localparam int WORD_W      = DATA_W + 1,
  localparam int IDX_W       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              halted,
  output logic              fault
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Operand word helpers
  function automatic logic opnd_bad(input logic [WORD_W-1:0] w);
    return w[WORD_W-1] && (w[DATA_W-1:IDX_W] != '0);
  endfunction

  // State
  state_e             state_q, state_d;
  opcode_e            opc_q, opc_d;
  logic [DATA_W-1:0]  pc_q, pc_d;
  logic [1:0]         idx_q, idx_d;
  logic [WORD_W-1:0]  w1_q, w1_d, w2_q, w2_d, w3_q, w3_d;
  logic [CHAR_W-1:0]  out_q, out_d;
  logic               fault_q, fault_d;

  // Datapath
  logic               rf_we;
  logic [DATA_W-1:0]  rf_wdata, rf_qa, rf_qb, rf_qc;
  logic [DATA_W-1:0]  va, vb, vc, alu_res, stk_top, stk_wdata, pc_next;
  logic               alu_div0, stk_push, stk_pop, stk_empty, stk_full;
  logic [1:0]         n_opnd, cap_cnt;
  logic               bad_any, dest_bad, trap;

  wstk_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_core_n), .we(rf_we), .waddr(w1_q[IDX_W-1:0]),
    .wdata(rf_wdata), .ra(w1_q[IDX_W-1:0]), .rb(w2_q[IDX_W-1:0]),
    .rc(w3_q[IDX_W-1:0]), .qa(rf_qa), .qb(rf_qb), .qc(rf_qc)
  );

  wstk_stack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_core_n), .push(stk_push), .pop(stk_pop),
    .wdata(stk_wdata), .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  wstk_alu #(.DATA_W(DATA_W)) u_alu (
    .op(opc_q), .x(vb), .y(vc), .res(alu_res), .div_zero(alu_div0)
  );

  assign va = w1_q[WORD_W-1] ? rf_qa : w1_q[DATA_W-1:0];
  assign vb = w2_q[WORD_W-1] ? rf_qb : w2_q[DATA_W-1:0];
  assign vc = w3_q[WORD_W-1] ? rf_qc : w3_q[DATA_W-1:0];

  assign n_opnd   = opnd_count(opc_q);
  assign cap_cnt  = opnd_count(opcode_e'(mem_rdata[4:0]));
  assign pc_next  = pc_q + DATA_W'(n_opnd) + DATA_W'(1);
  assign bad_any  = ((n_opnd >= 2'd1) && opnd_bad(w1_q)) ||
                    ((n_opnd >= 2'd2) && opnd_bad(w2_q)) ||
                    ((n_opnd == 2'd3) && opnd_bad(w3_q));
  assign dest_bad = writes_dest(opc_q) && !w1_q[WORD_W-1];

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    opc_d     = opc_q;
    pc_d      = pc_q;
    idx_d     = idx_q;
    w1_d      = w1_q;
    w2_d      = w2_q;
    w3_d      = w3_q;
    out_d     = out_q;
    fault_d   = fault_q;
    mem_addr  = pc_q + DATA_W'(idx_q);
    mem_wr_en = 1'b0;
    mem_wdata = {1'b0, vb};
    rf_we     = 1'b0;
    rf_wdata  = alu_res;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    stk_wdata = va;
    out_valid = 1'b0;
    in_ready  = 1'b0;
    trap      = 1'b0;

    case (state_q)
      ST_ISSUE: state_d = ST_CAPT;

      ST_CAPT: begin
        if (idx_q == 2'd0) begin
          if (mem_rdata > WORD_W'(OP_LAST)) begin
            trap = 1'b1;
          end else begin
            opc_d = opcode_e'(mem_rdata[4:0]);
            if (cap_cnt == 2'd0) state_d = ST_EXEC;
            else begin
              idx_d   = 2'd1;
              state_d = ST_ISSUE;
            end
          end
        end else begin
          case (idx_q)
            2'd1:    w1_d = mem_rdata;
            2'd2:    w2_d = mem_rdata;
            default: w3_d = mem_rdata;
          endcase
          if (idx_q == n_opnd) begin
            idx_d   = 2'd0;
            state_d = ST_EXEC;
          end else begin
            idx_d   = idx_q + 2'd1;
            state_d = ST_ISSUE;
          end
        end
      end

      ST_EXEC: begin
        state_d = ST_ISSUE;
        pc_d    = pc_next;
        if (bad_any || dest_bad) begin
          trap = 1'b1;
        end else begin
          case (opc_q)
            OP_HALT: state_d = ST_STOP;
            OP_SET: begin
              rf_we    = 1'b1;
              rf_wdata = vb;
            end
            OP_PUSH: begin
              if (stk_full) trap = 1'b1;
              else          stk_push = 1'b1;
            end
            OP_POP: begin
              if (stk_empty) trap = 1'b1;
              else begin
                rf_we    = 1'b1;
                rf_wdata = stk_top;
                stk_pop  = 1'b1;
              end
            end
            OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_AND, OP_OR, OP_NOT: rf_we = 1'b1;
            OP_MOD: begin
              if (alu_div0) trap = 1'b1;
              else          rf_we = 1'b1;
            end
            OP_JMP: pc_d = va;
            OP_JT:  if (va != '0) pc_d = vb;
            OP_JF:  if (va == '0) pc_d = vb;
            OP_RMEM: begin
              mem_addr = vb;
              state_d  = ST_RMEM;
            end
            OP_WMEM: begin
              mem_addr  = va;
              mem_wr_en = 1'b1;
              mem_wdata = {1'b0, vb};
            end
            OP_CALL: begin
              if (stk_full) trap = 1'b1;
              else begin
                stk_push  = 1'b1;
                stk_wdata = pc_next;
                pc_d      = va;
              end
            end
            OP_RET: begin
              if (stk_empty) trap = 1'b1;
              else begin
                stk_pop = 1'b1;
                pc_d    = stk_top;
              end
            end
            OP_OUT: begin
              out_d   = va[CHAR_W-1:0];
              state_d = ST_OUT;
            end
            OP_IN:   state_d = ST_IN;
            default: ;
          endcase
        end
      end

      ST_RMEM: begin
        rf_we    = 1'b1;
        rf_wdata = mem_rdata[DATA_W-1:0];
        state_d  = ST_ISSUE;
      end

      ST_OUT: begin
        out_valid = 1'b1;
        if (out_ready) state_d = ST_ISSUE;
      end

      ST_IN: begin
        in_ready = 1'b1;
        if (in_valid) begin
          rf_we    = 1'b1;
          rf_wdata = DATA_W'(in_data);
          state_d  = ST_ISSUE;
        end
      end

      default: ;
    endcase

    if (trap) begin
      fault_d   = 1'b1;
      state_d   = ST_STOP;
      rf_we     = 1'b0;
      stk_push  = 1'b0;
      stk_pop   = 1'b0;
      mem_wr_en = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_ISSUE;
      opc_q   <= OP_NOOP;
      pc_q    <= '0;
      idx_q   <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      w3_q    <= '0;
      out_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      opc_q   <= opc_d;
      pc_q    <= pc_d;
      idx_q   <= idx_d;
      w1_q    <= w1_d;
      w2_q    <= w2_d;
      w3_q    <= w3_d;
      out_q   <= out_d;
      fault_q <= fault_d;
    end
  end

  assign halted   = (state_q == ST_STOP);
  assign fault    = fault_q;
  assign out_data = out_q;

  // R12: once stopped, always stopped and silent
  assert_stop_sticky_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |=> halted);
  assert_stop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |-> (!out_valid && !in_ready && !mem_wr_en));
  // R13: an error always comes with a stop
  assert_fault_stops_R13: assert property (@(posedge clk) disable iff (!rst_core_n)
    fault |-> halted);
  // R10: a pending character is held steady until accepted
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R11: exactly one byte is taken per input instruction
  assert_in_single_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_ready && in_valid) |=> !in_ready);

endmodule

// File: tb/wstk_core_tb_top.sv
`timescale 1ns/1ps
module wstk_core_tb_top;

  localparam int MEM_N = 1024;
  localparam int DEPTH = 16;
  localparam int R0 = 32768, R1 = 32769, R2 = 32770, R3 = 32771;
  localparam int R4 = 32772, R5 = 32773, R6 = 32774, R7 = 32775;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] mem_addr;
  logic        mem_wr_en;
  logic [15:0] mem_wdata, mem_rdata;
  logic        out_valid, out_ready, in_valid, in_ready, halted, fault;
  logic [7:0]  out_data, in_data;

  always #4 clk = ~clk;   // 125 MHz

  wstk_core #(.STACK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .halted(halted), .fault(fault)
  );

  // Memory model with a loader port
  logic [15:0] mem [MEM_N];
  logic        ld_en, clr;
  logic [9:0]  ld_addr;
  logic [15:0] ld_data;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= 16'h0;
    end else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  int n_chk = 0, n_err = 0;
  int ptr;
  int rdy_mode;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] in_q[$];

  task automatic expect_b(input int b, input string req);
    exp_q.push_back(b[7:0]);
    tag_q.push_back(req);
  endtask

  // Monitor and handshake driver, away from the active edge
  bit         hold_pend;
  logic [7:0] held;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      hold_pend = 0;
      out_ready = 1'b0;
      in_valid  = 1'b0;
    end else begin
      if (hold_pend)
        chk(out_valid && out_data == held, "R10", "held byte", out_data, held);
      out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R12", "unexpected byte", out_data, 0);
        else begin
          logic [7:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, "output byte", out_data, e);
        end
      end
      hold_pend = out_valid && !out_ready;
      held      = out_data;
      in_valid  = (in_q.size() > 0);
      in_data   = in_valid ? in_q[0] : 8'h0;
      if (in_valid && in_ready) void'(in_q.pop_front());
    end
  end

  // Program builder
  task automatic put(input int v);
    ld_addr = ptr[9:0];
    ld_data = v[15:0];
    ld_en   = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    ptr++;
  endtask
  task automatic i0(input int op);
    put(op);
  endtask
  task automatic i1(input int op, input int a);
    put(op); put(a);
  endtask
  task automatic i2(input int op, input int a, input int b);
    put(op); put(a); put(b);
  endtask
  task automatic i3(input int op, input int a, input int b, input int c);
    put(op); put(a); put(b); put(c);
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    exp_q.delete();
    tag_q.delete();
    in_q.delete();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    ptr = 0;
  endtask

  task automatic run(input string name, input bit exp_fault, input int mode);
    bit stopped = 0;
    rdy_mode = mode;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (halted) begin
        stopped = 1;
        break;
      end
    end
    chk(stopped, exp_fault ? "R13" : "R12", {name, " stop reached"}, stopped, 1);
    chk(fault == exp_fault, exp_fault ? "R13" : "R12", {name, " fault flag"},
        fault, exp_fault);
    chk(exp_q.size() == 0, "R12", {name, " bytes still expected"}, exp_q.size(), 0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(halted && !out_valid && !mem_wr_en && !in_ready, "R12",
          {name, " quiet after stop"}, {out_valid, mem_wr_en, in_ready}, 0);
    end
    rst_n = 1'b0;
  endtask

  // Global watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int p;
    rst_n = 1'b0; ld_en = 1'b0; clr = 1'b0; ld_addr = '0; ld_data = '0;
    out_ready = 1'b0; in_valid = 1'b0; in_data = '0; rdy_mode = 0;

    // ---- Program 1: decode, arithmetic, logic, compares, branches
    begin_prog();
    repeat (3) @(negedge clk);
    chk(!halted && !fault && !out_valid && !in_ready, "R1", "reset outputs",
        {halted, fault, out_valid, in_ready}, 0);
    chk(mem_addr == 0, "R1", "reset fetch address", mem_addr, 0);
    i1(6, 3); i0(0);                                       // R3 skip over halt
    i2(1, R2, 2); i3(9, R2, R2, R2); i1(19, R2);   expect_b(4, "R2");
    i3(9, R1, 100, R2); i1(19, R1);                expect_b(104, "R2");
    i3(9, R0, R1, 16'h7FFE); i1(19, R0);           expect_b(102, "R4");
    i3(10, R0, 300, 200); i1(19, R0);              expect_b(8'h60, "R4");
    i3(4, R7, R0, 27232); i1(19, R7);              expect_b(1, "R4");
    i2(14, R0, 12); i3(4, R7, R0, 16'h7FF3); i1(19, R7); expect_b(1, "R5");
    i1(19, R0);                                    expect_b(8'hF3, "R5");
    i3(12, R2, 16'h0FFF, 16'h7F0C); i1(19, R2);    expect_b(8'h0C, "R5");
    i3(4, R7, R2, 16'h0F0C); i1(19, R7);           expect_b(1, "R5");
    i3(13, R2, 16'h0F, 16'h80); i1(19, R2);        expect_b(8'h8F, "R5");
    i3(11, R0, 8, 3); i1(19, R0);                  expect_b(2, "R5");
    i3(11, R0, R0, 2); i1(19, R0);                 expect_b(0, "R5");
    i3(5, R0, 3, 2); i1(19, R0);                   expect_b(1, "R6");
    i3(5, R0, 2, 2); i1(19, R0);                   expect_b(0, "R6");
    i3(5, R0, 16'h7FFF, 1); i1(19, R0);            expect_b(1, "R6");
    i3(4, R0, 5, 5); i1(19, R0);                   expect_b(1, "R6");
    i3(4, R0, 5, 6); i1(19, R0);                   expect_b(0, "R6");
    i2(7, 7, ptr + 5); i1(19, 8'hEE);              // R7 taken jt
    i2(8, 0, ptr + 5); i1(19, 8'hEE);              // R7 taken jf
    i2(7, 0, 0); i2(8, 1, 0);                      // R7 not taken
    i1(19, 8'h55);                                 expect_b(8'h55, "R7");
    i0(0); i1(19, 8'h99);                          // R12 never printed
    run("arith", 1'b0, 1);

    // ---- Program 2: stack, call/return, input
    begin_prog();
    i1(6, 9);
    i1(3, R3); i1(19, R3); i1(2, R3); i0(18);      // subroutine at 2
    i1(2, 1); i2(1, R0, 3); i1(2, R0); i1(3, R1); i1(3, R2);
    i1(19, R1);                                    expect_b(3, "R8");
    i1(19, R2);                                    expect_b(1, "R8");
    expect_b(ptr + 2, "R8"); i1(17, 2);
    i1(19, 8'h42);                                 expect_b(8'h42, "R8");
    i1(20, R4); i1(19, R4);                        expect_b(8'h30, "R11");
    i1(20, R5); i3(9, R6, R4, R5); i1(19, R6);     expect_b(8'h41, "R11");
    i0(0);
    in_q.push_back(8'h30); in_q.push_back(8'h11);
    run("stack", 1'b0, 0);
    chk(in_q.size() == 0, "R11", "input bytes consumed", in_q.size(), 0);

    // ---- Program 3: memory access and self-modifying code
    begin_prog();
    i1(6, 3); i0(0);
    i2(15, R0, 1); i1(19, R0);                     expect_b(3, "R9");
    i2(16, 200, 16'h1234); i2(1, R2, 200); i2(15, R1, R2); i1(19, R1);
    expect_b(8'h34, "R9");
    p = ptr;
    i2(16, p + 7, 8'h22); i2(16, p + 8, 21);
    i1(19, 8'h11);                                 expect_b(8'h22, "R9");
    i0(0); i1(19, 8'h77);                          expect_b(8'h77, "R9");
    i0(0);
    run("selfmod", 1'b0, 1);

    // ---- Error stops (R13)
    begin_prog(); i1(19, 1); expect_b(1, "R13"); i1(3, R0); i0(0);
    run("pop-empty", 1'b1, 0);
    begin_prog(); i1(19, 1); expect_b(1, "R13"); i0(18); i0(0);
    run("ret-empty", 1'b1, 0);
    begin_prog(); i1(19, 1); expect_b(1, "R13"); i0(22); i0(0);
    run("bad-opcode", 1'b1, 0);
    begin_prog(); i1(19, 1); expect_b(1, "R13"); i3(11, R0, 5, 0); i0(0);
    run("mod-zero", 1'b1, 0);
    begin_prog(); i1(19, 1); expect_b(1, "R13"); i3(9, R0, 32776, 1); i0(0);
    run("bad-operand", 1'b1, 0);
    begin_prog(); i1(19, 1); expect_b(1, "R13"); i2(1, 5, 1); i0(0);
    run("literal-dest", 1'b1, 0);
    begin_prog(); i1(2, 1); i1(6, 0);
    run("stack-full", 1'b1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule